// File: doc/BRIEF.md
# Serial Port Clock Prescaler

This block sits beside a microcontroller UART and produces the single-cycle tick that paces bit shifting in two of the serial modes. The synchronous shift mode and the fixed-rate asynchronous mode each take their pace from the oscillator clock. The system clock divide select, the 2x/4x multiplier factor and one speed bit per mode pick one of a small set of periods. The tick is a one-cycle pulse that repeats at the chosen period. The shifter, framing and the timer-driven serial modes are outside this block.

Any change on a control input restarts the count. The next tick then arrives one full period of the new setting later. Phases from the old setting never leak into the new one. A disable input holds the counter in its reload state and suppresses every tick. The period is computed from the controls, not read from a stored table. The divisors are parameters, and the counter width is derived from the largest period.

Top module: `serial_clk_prescaler`

## Requirements
- R1: While reset is applied, and until the block is enabled after reset, `tick` is 0.
- R2: With `ser_mode2`=0, `div_sel`=2'b00 and `mult_x4`=1, the tick period is 3 clocks when `m0_fast`=0 and 1 clock when `m0_fast`=1.
- R3: With `ser_mode2`=0, `div_sel`=2'b00 and `mult_x4`=0, the tick period is 6 clocks when `m0_fast`=0 and 2 clocks when `m0_fast`=1.
- R4: With `ser_mode2`=0 and `div_sel` equal to 2'b01 or 2'b10, the tick period is 12 clocks when `m0_fast`=0 and 4 clocks when `m0_fast`=1, for either value of `mult_x4`.
- R5: With `ser_mode2`=0 and `div_sel`=2'b11, the tick period is 3072 clocks when `m0_fast`=0 and 1024 clocks when `m0_fast`=1.
- R6: With `ser_mode2`=1 and `div_sel` equal to 2'b00, 2'b01 or 2'b10, the tick period is 64 clocks when `m2_double`=0 and 32 clocks when `m2_double`=1, for either value of `mult_x4`.
- R7: With `ser_mode2`=1 and `div_sel`=2'b11, the tick period is 16384 clocks when `m2_double`=0 and 8192 clocks when `m2_double`=1.
- R8: Any change of any control input, including one that leaves the period unchanged, restarts the count. The cycle after the change carries no tick, and the first tick follows P clock edges after the edge that saw the change, where P is the new period.
- R9: When the period is 1 clock, `tick` is 1 on every cycle while the controls stay unchanged and `enable` stays 1.
- R10: While `enable` is 0, `tick` is 0 after every clock edge. After `enable` rises, the first tick follows P enabled clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable | input | 1 | 1 runs the prescaler; 0 holds it in reload with no ticks |
| ser_mode2 | input | 1 | 0 selects synchronous shift mode, 1 selects fixed-rate mode |
| div_sel | input | 2 | System clock divide select |
| mult_x4 | input | 1 | Multiplier factor: 1 = x4, 0 = x2 |
| m0_fast | input | 1 | Speed bit for synchronous shift mode |
| m2_double | input | 1 | Double-rate bit for fixed-rate mode |
| tick | output | 1 | One-cycle pulse at the selected period |

## Verification
The case that is hardest to reach is a restart caused by a bit that does not affect the current period, such as the speed bit of the other mode. Such a change leaves the period as it was, so the restart shows only as a longer gap between ticks. The stimulus waits for a tick, lets part of a period elapse, toggles an unrelated bit, and then counts the edges to the next tick. The longest divisors in both modes are also driven for two full periods each, so that the upper bits of the counter are exercised.

// File: rtl/scp_pkg.sv
package scp_pkg;

  // Control word captured for restart detection, most significant first.
  typedef struct packed {
    logic       mode2;
    logic [1:0] div_sel;
    logic       mult_x4;
    logic       m0_fast;
    logic       m2_double;
  } scp_ctl_t;

  localparam int unsigned CTL_W = $bits(scp_ctl_t);

endpackage

// File: rtl/scp_rst_sync.sv
module scp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/scp_period_lut.sv
module scp_period_lut
  import scp_pkg::*;
#(
  parameter int unsigned M0_SLOW_MULT = 3,
  parameter int unsigned M0_DIV3_K    = 1024,
  parameter int unsigned M2_BASE      = 64,
  parameter int unsigned M2_DIV3_BASE = 16384,
  parameter int unsigned CNT_W        = 14
) (
  input  scp_ctl_t         ctl_i,
  output logic [CNT_W-1:0] reload_o
);

  logic [31:0] m0_unit;
  logic [31:0] m2_full;
  logic [31:0] period;

  always_comb begin
    // Mode-0 unit: the fast-speed period; the slow speed multiplies it.
    if (ctl_i.div_sel == 2'b11) begin
      m0_unit = 32'(M0_DIV3_K);
    end else if (ctl_i.div_sel == 2'b00) begin
      m0_unit = ctl_i.mult_x4 ? 32'd1 : 32'd2;
    end else begin
      m0_unit = 32'd4;
    end

    m2_full = (ctl_i.div_sel == 2'b11) ? 32'(M2_DIV3_BASE) : 32'(M2_BASE);

    if (ctl_i.mode2) begin
      period = ctl_i.m2_double ? (m2_full >> 1) : m2_full;
    end else begin
      period = ctl_i.m0_fast ? m0_unit : m0_unit * 32'(M0_SLOW_MULT);
    end

    reload_o = CNT_W'(period - 32'd1);
  end

endmodule

// File: rtl/scp_tick_counter.sv
module scp_tick_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!enable || restart) begin
      cnt_d = reload;
    end else if (cnt_zero) begin
      cnt_d  = reload;
      tick_d = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

endmodule

// File: rtl/serial_clk_prescaler.sv
module serial_clk_prescaler
  import scp_pkg::*;
#(
  parameter int unsigned M0_SLOW_MULT = 3,
  parameter int unsigned M0_DIV3_K    = 1024,
  parameter int unsigned M2_BASE      = 64,
  parameter int unsigned M2_DIV3_BASE = 16384,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       ser_mode2,
  input  logic [1:0] div_sel,
  input  logic       mult_x4,
  input  logic       m0_fast,
  input  logic       m2_double,
  output logic       tick
);

  localparam int unsigned MAX_PERIOD = (M2_DIV3_BASE > M0_DIV3_K * M0_SLOW_MULT)
                                       ? M2_DIV3_BASE : M0_DIV3_K * M0_SLOW_MULT;
  localparam int unsigned CNT_W      = (MAX_PERIOD > 2) ? $clog2(MAX_PERIOD) : 1;

  logic             rst_sync_n;
  scp_ctl_t         ctl_now;
  scp_ctl_t         ctl_q;
  logic             primed_q;
  logic             restart;
  logic [CNT_W-1:0] reload;

  scp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign ctl_now = '{mode2: ser_mode2, div_sel: div_sel, mult_x4: mult_x4,
                     m0_fast: m0_fast, m2_double: m2_double};

  // Restart on the first edge after reset and on any control change.
  assign restart = !primed_q || (ctl_now != ctl_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      ctl_q    <= ctl_now;
      primed_q <= 1'b1;
    end
  end

  scp_period_lut #(
    .M0_SLOW_MULT (M0_SLOW_MULT),
    .M0_DIV3_K    (M0_DIV3_K),
    .M2_BASE      (M2_BASE),
    .M2_DIV3_BASE (M2_DIV3_BASE),
    .CNT_W        (CNT_W)
  ) u_lut (
    .ctl_i    (ctl_now),
    .reload_o (reload)
  );

  scp_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .enable  (enable),
    .restart (restart),
    .reload  (reload),
    .tick    (tick)
  );

endmodule

// File: rtl/scp_prescaler_chk.sv
module scp_prescaler_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic       enable,
  input logic [5:0] ctl,
  input logic       tick
);

  function automatic logic one_clk(input logic [5:0] c);
    return !c[5] && (c[4:3] == 2'b00) && c[2] && c[1];
  endfunction

  // R10: disabled cycles never produce a tick
  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    !enable |=> !tick);

  // R8: a control change is followed by a cycle with no tick
  p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    !$stable(ctl) |=> !tick);

  // R9: a one-clock period keeps ticking while settings hold
  p_every_cycle_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (tick && enable && $stable(ctl) && one_clk(ctl)) |=> tick);

  // R2-R7 share this: any period above one leaves a gap after a tick
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (tick && !one_clk($past(ctl))) |=> !tick);

  // R1: no tick while the synchronized reset is held
  always_comb begin
    if (!rst_ok) begin
      p_reset_quiet_r1: assert (!tick);
    end
  end

endmodule

bind serial_clk_prescaler scp_prescaler_chk u_chk (
  .clk    (clk),
  .rst_ok (rst_sync_n),
  .enable (enable),
  .ctl    ({ser_mode2, div_sel, mult_x4, m0_fast, m2_double}),
  .tick   (tick)
);

// File: tb/tb_serial_clk_prescaler.sv
`timescale 1ns/1ps
module tb_serial_clk_prescaler;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic       ser_mode2;
  logic [1:0] div_sel;
  logic       mult_x4;
  logic       m0_fast;
  logic       m2_double;
  logic       tick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  serial_clk_prescaler dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ser_mode2(ser_mode2),
    .div_sel(div_sel), .mult_x4(mult_x4), .m0_fast(m0_fast),
    .m2_double(m2_double), .tick(tick)
  );

  function automatic int ref_period(bit m2, bit [1:0] d, bit x4, bit f, bit dbl);
    if (m2) return (d == 2'd3) ? (dbl ? 8192 : 16384) : (dbl ? 32 : 64);
    case (d)
      2'd0:    return x4 ? (f ? 1 : 3) : (f ? 2 : 6);
      2'd3:    return f ? 1024 : 3072;
      default: return f ? 4 : 12;
    endcase
  endfunction

  function automatic string req_of(bit m2, bit [1:0] d, bit x4);
    if (m2) return (d == 2'd3) ? "R7" : "R6";
    if (d == 2'd0) return x4 ? "R2" : "R3";
    return (d == 2'd3) ? "R5" : "R4";
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Behavioural reference: phase count since the last restart.
  bit       exp_tick = 1'b0;
  int       phase    = 0;
  bit [5:0] prev_ctl = '0;
  always @(posedge clk) begin
    bit [5:0] cur;
    cur = {ser_mode2, div_sel, mult_x4, m0_fast, m2_double};
    if (!rst_n || !enable || cur != prev_ctl) begin
      exp_tick = 1'b0;
      phase    = 0;
    end else begin
      phase++;
      if (phase >= ref_period(ser_mode2, div_sel, mult_x4, m0_fast, m2_double)) begin
        exp_tick = 1'b1;
        phase    = 0;
      end else begin
        exp_tick = 1'b0;
      end
    end
    prev_ctl = cur;
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (rst_n) chk(tick === exp_tick, req_of(ser_mode2, div_sel, mult_x4),
                   int'(tick), int'(exp_tick));
  end

  task automatic set_ctl(bit m2, bit [1:0] d, bit x4, bit f, bit dbl);
    ser_mode2 = m2; div_sel = d; mult_x4 = x4; m0_fast = f; m2_double = dbl;
  endtask

  // Edges (seen as negedges) from now until the next tick.
  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 40000);
  endtask

  task automatic run_case(bit m2, bit [1:0] d, bit x4, bit f, bit dbl);
    int n;
    int p;
    string req;
    p   = ref_period(m2, d, x4, f, dbl);
    req = req_of(m2, d, x4);
    @(negedge clk);
    set_ctl(m2, d, x4, f, dbl);
    wait_tick(n);
    chk(n == p + 1, "R8", n, p + 1);
    wait_tick(n);
    chk(n == p, req, n, p);
    wait_tick(n);
    chk(n == p, req, n, p);
  endtask

  initial begin
    int n;
    int hits;
    rst_n = 1'b0;
    enable = 1'b0;
    set_ctl(0, 2'd0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(tick == 1'b0, "R1", int'(tick), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tick == 1'b0, "R1", int'(tick), 0);
    enable = 1'b1;

    // R2, R3: divide select 00 in mode 0
    run_case(0, 2'd0, 1, 0, 0);
    run_case(0, 2'd0, 1, 1, 0);
    run_case(0, 2'd0, 0, 0, 0);
    run_case(0, 2'd0, 0, 1, 0);
    // R4: factor bit has no effect for 01 and 10
    for (int d = 1; d <= 2; d++) begin
      for (int x = 0; x <= 1; x++) begin
        run_case(0, 2'(d), 1'(x), 0, 0);
        run_case(0, 2'(d), 1'(x), 1, 0);
      end
    end
    // R5
    run_case(0, 2'd3, 0, 0, 0);
    run_case(0, 2'd3, 1, 1, 0);
    // R6: three divide selects, both factors
    for (int d = 0; d <= 2; d++) begin
      run_case(1, 2'(d), 0, 0, 0);
      run_case(1, 2'(d), 1, 0, 1);
    end
    // R7
    run_case(1, 2'd3, 0, 0, 0);
    run_case(1, 2'd3, 0, 0, 1);

    // R9: period of one ticks every cycle
    @(negedge clk);
    set_ctl(0, 2'd0, 1, 1, 0);
    repeat (2) @(negedge clk);
    hits = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tick) hits++;
    end
    chk(hits == 20, "R9", hits, 20);

    // R8: unrelated bit change mid-period restarts the count
    run_case(1, 2'd0, 0, 0, 0);
    repeat (20) @(negedge clk);
    m0_fast = 1'b1;
    @(negedge clk);
    chk(tick == 1'b0, "R8", int'(tick), 0);
    n = 1;
    while (!tick && n < 40000) begin
      @(negedge clk);
      n++;
    end
    chk(n == 65, "R8", n, 65);

    // R10: disable suppresses ticks, restart after enable
    @(negedge clk);
    set_ctl(0, 2'd1, 0, 1, 0);
    enable = 1'b0;
    hits = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (tick) hits++;
    end
    chk(hits == 0, "R10", hits, 0);
    enable = 1'b1;
    wait_tick(n);
    chk(n == 4, "R10", n, 4);
    wait_tick(n);
    chk(n == 4, "R10", n, 4);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule